// File: doc/BRIEF.md
# Disk Request Register Interface

This block sits on a CPU's byte-wide I/O bus and collects the description of one sector transfer before handing it to a storage back end. Software writes byte ports to set the pieces of the request. The DMA address, sector number and track number are each loaded as a low byte and a high byte. The drive index and the DMA memory bank each take one byte. The bank number lets a transfer reach a memory bank other than the one the CPU has mapped in.

An I/O read of one of two trigger ports launches the transfer: one trigger means "read from disk", the other means "write to disk". The block stalls that read with a wait signal while the back end works. When the back end reports done, the block returns the status byte it supplied as the data of the same I/O read. Once the CPU ends the read cycle, the interface goes back to idle. The back end sees a level-valid request together with all latched fields, and those fields hold still until it answers.

Top module: `dreq_port_if`

## Requirements
- R1: After reset, req_valid, io_wait and io_rdata are 0, and req_write, req_dma, req_sector, req_track, req_drive and req_bank are all 0.
- R2: A one-cycle io_wr pulse with io_addr = BASE_ADDR + offset loads io_wdata into the byte at that offset, while the block is idle. The offsets are: 0 DMA address low, 1 DMA address high, 2 sector low, 3 sector high, 4 track low, 5 track high, 6 drive index, 7 bank number. The loaded values appear on req_dma, req_sector, req_track, req_drive and req_bank.
- R3: While idle, holding io_rd with io_addr = BASE_ADDR + 8 starts a disk read (req_write = 0), and BASE_ADDR + 9 starts a disk write (req_write = 1). req_valid is 1 from the clock edge at which the read is first sampled.
- R4: io_wait is 1 as soon as io_rd addresses a trigger port in the idle state. It stays 1 while req_valid is 1, and falls at the edge that samples be_done.
- R5: After be_done, io_rdata carries the be_status byte sampled with be_done, until io_rd is released. At all other times io_rdata is 0.
- R6: While req_valid is 1, req_write and all request fields hold constant.
- R7: Writes to any register port while a request is pending or finishing are ignored, so the next request still carries the earlier values.
- R8: Writes outside offsets 0 to 7 of the 16-port window starting at BASE_ADDR, and writes to other addresses, change nothing. A read of a non-trigger port starts nothing and returns 0.
- R9: req_valid falls at the edge that samples be_done. No new request starts until io_rd has been released, even if io_rd stays asserted on the trigger port.

Ports table continues below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W | I/O port address |
| io_wdata | input | DATA_W | I/O write data |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_rd | input | 1 | I/O read, held for the whole read cycle |
| io_rdata | output | DATA_W | I/O read data (completion status) |
| io_wait | output | 1 | Stall request to the CPU |
| req_valid | output | 1 | Request pending to the back end |
| req_write | output | 1 | 1 = write to disk, 0 = read from disk |
| req_dma | output | 2*DATA_W | DMA memory address |
| req_sector | output | 2*DATA_W | Sector number |
| req_track | output | 2*DATA_W | Track number |
| req_drive | output | DATA_W | Drive index |
| req_bank | output | DATA_W | DMA memory bank |
| be_done | input | 1 | Back end finished, one-cycle pulse |
| be_status | input | DATA_W | Status byte, valid with be_done |

## Verification
A wrong byte enable or a missing lock-out shows up as a request field that differs from the bench's shadow copy. This is visible at the very next req_valid, or within one cycle of a stray write during a pending request. A controller state that is stuck or skips a step shows up at the CPU side within one cycle. Either io_wait never drops, or a stale or zero status is returned, or a second request starts while the trigger read is still held. The scoreboard pairs each launched request with its expected fields and status, so a lost or duplicated request is caught at the next trigger.

// File: rtl/dreq_pkg.sv
`timescale 1ns/1ps
package dreq_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_BUSY = 2'd1,
      ST_DONE = 2'd2
   } dreq_state_e;

   localparam int unsigned N_BYTE_REGS = 8;
   localparam int unsigned OFF_DMA_LO  = 0;
   localparam int unsigned OFF_DMA_HI  = 1;
   localparam int unsigned OFF_SEC_LO  = 2;
   localparam int unsigned OFF_SEC_HI  = 3;
   localparam int unsigned OFF_TRK_LO  = 4;
   localparam int unsigned OFF_TRK_HI  = 5;
   localparam int unsigned OFF_DRIVE   = 6;
   localparam int unsigned OFF_BANK    = 7;
   localparam int unsigned OFF_RD_TRIG = 8;
   localparam int unsigned OFF_WR_TRIG = 9;
endpackage

// File: rtl/dreq_decode.sv
`timescale 1ns/1ps
module dreq_decode #(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned WIN_BITS = 4,
   parameter int unsigned NREG     = 8,
   parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic              accept_wr,
   output logic [NREG-1:0]   wr_sel,
   output logic              rd_trig,
   output logic              wr_trig
);
   logic                hit;
   logic [WIN_BITS-1:0] off;

   assign hit = (io_addr[ADDR_W-1:WIN_BITS] == BASE_ADDR[ADDR_W-1:WIN_BITS]);
   assign off = io_addr[WIN_BITS-1:0];

   for (genvar i = 0; i < NREG; i++) begin : g_sel
      assign wr_sel[i] = io_wr & accept_wr & hit & (off == WIN_BITS'(i));
   end

   assign rd_trig = io_rd & hit & (off == WIN_BITS'(dreq_pkg::OFF_RD_TRIG));
   assign wr_trig = io_rd & hit & (off == WIN_BITS'(dreq_pkg::OFF_WR_TRIG));
endmodule

// File: rtl/dreq_regfile.sv
`timescale 1ns/1ps
module dreq_regfile #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned NREG   = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NREG-1:0]        wr_sel,
   input  logic [DATA_W-1:0]      wdata,
   output logic [NREG*DATA_W-1:0] q
);
   for (genvar i = 0; i < NREG; i++) begin : g_byte
      logic [DATA_W-1:0] r_q;
      always_ff @(posedge clk) begin
         if (!rst_n)         r_q <= '0;
         else if (wr_sel[i]) r_q <= wdata;
      end
      assign q[i*DATA_W +: DATA_W] = r_q;
   end
endmodule

// File: rtl/dreq_ctrl.sv
`timescale 1ns/1ps
module dreq_ctrl #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_trig,
   input  logic              wr_trig,
   input  logic              io_rd,
   input  logic              be_done,
   input  logic [DATA_W-1:0] be_status,
   output logic              idle,
   output logic              req_valid,
   output logic              req_write,
   output logic              io_wait,
   output logic [DATA_W-1:0] io_rdata
);
   import dreq_pkg::*;

   dreq_state_e       state_q;
   logic              op_q;
   logic [DATA_W-1:0] status_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         op_q     <= 1'b0;
         status_q <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (rd_trig | wr_trig) begin
               op_q    <= wr_trig;
               state_q <= ST_BUSY;
            end
            ST_BUSY: if (be_done) begin
               status_q <= be_status;
               state_q  <= ST_DONE;
            end
            ST_DONE: if (!io_rd) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign idle      = (state_q == ST_IDLE);
   assign req_valid = (state_q == ST_BUSY);
   assign req_write = op_q;
   assign io_wait   = (idle & (rd_trig | wr_trig)) | req_valid;
   assign io_rdata  = (state_q == ST_DONE) ? status_q : '0;
endmodule

// File: rtl/dreq_port_if.sv
`timescale 1ns/1ps
module dreq_port_if #(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned WIN_BITS = 4,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h40
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   io_addr,
   input  logic [DATA_W-1:0]   io_wdata,
   input  logic                io_wr,
   input  logic                io_rd,
   output logic [DATA_W-1:0]   io_rdata,
   output logic                io_wait,
   output logic                req_valid,
   output logic                req_write,
   output logic [2*DATA_W-1:0] req_dma,
   output logic [2*DATA_W-1:0] req_sector,
   output logic [2*DATA_W-1:0] req_track,
   output logic [DATA_W-1:0]   req_drive,
   output logic [DATA_W-1:0]   req_bank,
   input  logic                be_done,
   input  logic [DATA_W-1:0]   be_status
);
   import dreq_pkg::*;

   localparam int unsigned NREG   = N_BYTE_REGS;
   localparam int unsigned NPORTS = NREG + 2;

   if (WIN_BITS >= ADDR_W) begin : g_bad_win
      $error("WIN_BITS must be smaller than ADDR_W");
   end
   if ((1 << WIN_BITS) < NPORTS) begin : g_bad_size
      $error("port window too small for all registers and triggers");
   end
   if (BASE_ADDR[WIN_BITS-1:0] != '0) begin : g_bad_base
      $error("BASE_ADDR must be aligned to the port window");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be at least 1");
   end

   logic [NREG-1:0]        wr_sel;
   logic                   rd_trig;
   logic                   wr_trig;
   logic                   idle;
   logic [NREG*DATA_W-1:0] regs;

   dreq_decode #(
      .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .NREG(NREG), .BASE_ADDR(BASE_ADDR)
   ) u_decode (
      .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd), .accept_wr(idle),
      .wr_sel(wr_sel), .rd_trig(rd_trig), .wr_trig(wr_trig)
   );

   dreq_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .wdata(io_wdata), .q(regs)
   );

   dreq_ctrl #(.DATA_W(DATA_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .rd_trig(rd_trig), .wr_trig(wr_trig),
      .io_rd(io_rd), .be_done(be_done), .be_status(be_status),
      .idle(idle), .req_valid(req_valid), .req_write(req_write),
      .io_wait(io_wait), .io_rdata(io_rdata)
   );

   assign req_dma    = {regs[OFF_DMA_HI*DATA_W +: DATA_W], regs[OFF_DMA_LO*DATA_W +: DATA_W]};
   assign req_sector = {regs[OFF_SEC_HI*DATA_W +: DATA_W], regs[OFF_SEC_LO*DATA_W +: DATA_W]};
   assign req_track  = {regs[OFF_TRK_HI*DATA_W +: DATA_W], regs[OFF_TRK_LO*DATA_W +: DATA_W]};
   assign req_drive  = regs[OFF_DRIVE*DATA_W +: DATA_W];
   assign req_bank   = regs[OFF_BANK*DATA_W +: DATA_W];
endmodule

// File: rtl/dreq_port_if_chk.sv
`timescale 1ns/1ps
module dreq_port_if_chk #(
   parameter int unsigned DATA_W = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                io_rd,
   input logic                io_wr,
   input logic                io_wait,
   input logic [DATA_W-1:0]   io_rdata,
   input logic                req_valid,
   input logic                req_write,
   input logic [2*DATA_W-1:0] req_dma,
   input logic [2*DATA_W-1:0] req_sector,
   input logic [2*DATA_W-1:0] req_track,
   input logic [DATA_W-1:0]   req_drive,
   input logic [DATA_W-1:0]   req_bank,
   input logic                be_done
);
   p_hold_fields_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !be_done) |=> ($stable(req_dma) && $stable(req_sector) &&
         $stable(req_track) && $stable(req_drive) && $stable(req_bank) && $stable(req_write)));

   p_stall_while_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> io_wait);

   p_drop_on_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && be_done) |=> !req_valid);

   p_quiet_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (io_rdata == '0));

   p_start_from_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_valid) |-> $past(io_rd));

   p_write_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && io_wr) |=> ($stable(req_dma) && $stable(req_bank) && $stable(req_drive)));
endmodule

bind dreq_port_if dreq_port_if_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .io_rd(io_rd), .io_wr(io_wr), .io_wait(io_wait),
   .io_rdata(io_rdata), .req_valid(req_valid), .req_write(req_write),
   .req_dma(req_dma), .req_sector(req_sector), .req_track(req_track),
   .req_drive(req_drive), .req_bank(req_bank), .be_done(be_done)
);

// File: tb/dreq_port_if_tb.sv
`timescale 1ns/1ps
module dreq_port_if_tb;
   localparam logic [7:0] BASE = 8'h40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  io_addr = '0;
   logic [7:0]  io_wdata = '0;
   logic        io_wr = 1'b0;
   logic        io_rd = 1'b0;
   logic [7:0]  io_rdata;
   logic        io_wait;
   logic        req_valid;
   logic        req_write;
   logic [15:0] req_dma, req_sector, req_track;
   logic [7:0]  req_drive, req_bank;
   logic        be_done = 1'b0;
   logic [7:0]  be_status = '0;

   always #4 clk = ~clk;

   dreq_port_if u_dut (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
      .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata), .io_wait(io_wait),
      .req_valid(req_valid), .req_write(req_write), .req_dma(req_dma),
      .req_sector(req_sector), .req_track(req_track), .req_drive(req_drive),
      .req_bank(req_bank), .be_done(be_done), .be_status(be_status)
   );

   typedef struct {
      bit          wr;
      logic [15:0] dma, sec, trk;
      logic [7:0]  drv, bnk, st;
      int          dly;
      bit          poke;
      string       tag;
   } item_t;

   item_t      exp_q[$];
   logic [7:0] sh [8];
   int         checks = 0;
   int         errors = 0;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic io_out(logic [7:0] a, logic [7:0] v);
      @(negedge clk);
      io_addr = a; io_wdata = v; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   // R2: accepted register write, mirrored in the shadow copy
   task automatic put(int off, logic [7:0] v);
      io_out(BASE + 8'(off), v);
      sh[off] = v;
   endtask

   // driver: push the expected request, then run the trigger read
   task automatic issue(bit wr, logic [7:0] st, int dly, bit poke, int hold, string tag);
      item_t it;
      it.wr = wr; it.dma = {sh[1], sh[0]}; it.sec = {sh[3], sh[2]};
      it.trk = {sh[5], sh[4]}; it.drv = sh[6]; it.bnk = sh[7];
      it.st = st; it.dly = dly; it.poke = poke; it.tag = tag;
      exp_q.push_back(it);
      @(negedge clk);
      io_addr = BASE + (wr ? 8'd9 : 8'd8);
      io_rd = 1'b1;
      @(negedge clk);
      chk("R3 request raised", {31'd0, req_valid}, 32'd1);
      chk("R3 operation type", {31'd0, req_write}, {31'd0, wr});
      while (io_wait) @(negedge clk);
      chk("R5 status returned", {24'd0, io_rdata}, {24'd0, st});
      for (int h = 0; h < hold; h++) begin
         @(negedge clk);
         chk("R9 no restart while read held", {31'd0, req_valid}, 32'd0);
         chk("R5 status held", {24'd0, io_rdata}, {24'd0, st});
      end
      io_rd = 1'b0;
      @(negedge clk);
      chk("R5 data zero after release", {24'd0, io_rdata}, 32'd0);
      chk("R4 no wait when idle", {31'd0, io_wait}, 32'd0);
   endtask

   // monitor / back-end model: pop the scoreboard and compare
   initial begin
      forever begin
         @(negedge clk);
         if (req_valid) begin
            item_t it;
            if (exp_q.size() == 0) begin
               chk("R3 unexpected request", 32'd1, 32'd0);
               it.dly = 1; it.st = '0; it.poke = 0;
            end else begin
               it = exp_q.pop_front();
               chk({it.tag, " dma"},    {16'd0, req_dma},    {16'd0, it.dma});
               chk({it.tag, " sector"}, {16'd0, req_sector}, {16'd0, it.sec});
               chk({it.tag, " track"},  {16'd0, req_track},  {16'd0, it.trk});
               chk({it.tag, " drive"},  {24'd0, req_drive},  {24'd0, it.drv});
               chk({it.tag, " bank"},   {24'd0, req_bank},   {24'd0, it.bnk});
            end
            for (int k = 0; k < it.dly; k++) begin
               if (it.poke && k == 0) begin
                  logic [7:0] a;
                  a = io_addr;
                  io_addr = BASE; io_wdata = 8'hEE; io_wr = 1'b1;
                  @(negedge clk);
                  io_wr = 1'b0; io_addr = a;
                  chk("R7 write ignored while pending", {16'd0, req_dma}, {16'd0, it.dma});
               end else begin
                  @(negedge clk);
               end
               chk("R6 fields stable", {req_bank, req_drive, req_track[7:0], req_sector[7:0]},
                   {it.bnk, it.drv, it.trk[7:0], it.sec[7:0]});
               chk("R4 wait while pending", {31'd0, io_wait}, 32'd1);
            end
            be_done = 1'b1; be_status = it.st;
            @(negedge clk);
            be_done = 1'b0; be_status = 8'h00;
            chk("R9 request dropped after done", {31'd0, req_valid}, 32'd0);
            chk("R4 wait released after done", {31'd0, io_wait}, 32'd0);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 8; i++) sh[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 req_valid", {31'd0, req_valid}, 32'd0);
      chk("R1 io_wait", {31'd0, io_wait}, 32'd0);
      chk("R1 io_rdata", {24'd0, io_rdata}, 32'd0);
      chk("R1 req_write", {31'd0, req_write}, 32'd0);
      chk("R1 fields", {req_dma, req_sector}, 32'd0);
      chk("R1 fields", {req_track, req_drive, req_bank}, 32'd0);

      issue(0, 8'h00, 3, 0, 0, "R1 zero fields");

      put(0, 8'h34); put(1, 8'h12); put(2, 8'h78); put(3, 8'h56);
      put(4, 8'hBC); put(5, 8'h9A); put(6, 8'h03); put(7, 8'h01);
      issue(0, 8'h5A, 2, 0, 0, "R2 all bytes");
      issue(1, 8'hA5, 5, 0, 2, "R3 write trigger");

      put(7, 8'h02); put(2, 8'hFF);
      issue(1, 8'h01, 1, 0, 0, "R2 partial update");

      issue(0, 8'h7E, 4, 1, 0, "R6 pending with poke");
      issue(0, 8'h33, 2, 0, 0, "R7 after ignored write");

      // R8: outside window, unused offsets and trigger port writes
      io_out(BASE + 8'd16, 8'h99);
      io_out(BASE + 8'd10, 8'h88);
      io_out(BASE + 8'd8, 8'h77);
      io_out(8'h00, 8'h66);
      @(negedge clk);
      io_addr = BASE + 8'd3; io_rd = 1'b1;
      @(negedge clk);
      chk("R8 non-trigger read no wait", {31'd0, io_wait}, 32'd0);
      chk("R8 non-trigger read no request", {31'd0, req_valid}, 32'd0);
      chk("R8 non-trigger read data", {24'd0, io_rdata}, 32'd0);
      io_rd = 1'b0;
      issue(1, 8'h44, 1, 0, 0, "R8 fields unchanged");

      for (int i = 0; i < 6; i++) begin
         for (int j = 0; j < 8; j++) put(j, 8'((i * 37 + j * 11 + 5) & 8'hFF));
         issue(i[0], 8'(8'h10 + i), 1 + i, 0, i % 2, "R2 pattern");
      end

      repeat (4) @(negedge clk);
      chk("R9 no leftover requests", exp_q.size(), 32'd0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule